// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block moves a 32-bit word by a variable distance in one of five ways: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right that takes its top bit from the old carry. Each operation also produces a carry-out bit. The carry-out goes to the flag logic of the execute stage that surrounds the block.

The shift distance is an 8-bit value, so it can be much larger than the word width. The block has exact rules for distances of zero, exactly the word width, and anything beyond the word width. It takes the source word, a 3-bit operation selector, the distance and the current carry flag. A control module decodes the selector and the distance into a small set of strobes. A datapath module forms the result and the carry from those strobes. An optional output register, on by default, adds one cycle of latency.

Top module: `barrel_shift_unit`

## Requirements
- R1: The selector codes are 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate-right-extended. For codes 0 to 3, a distance of 0 returns the source unchanged, and the carry-out equals the incoming carry.
- R2: For logical left with a distance n from 1 to 31, the result is the source shifted left by n with zeros filled in, and the carry-out is source bit 32−n.
- R3: For logical left with a distance of 32, the result is 0 and the carry-out is source bit 0. For distances from 33 to 255, the result is 0 and the carry-out is 0.
- R4: For logical right with a distance n from 1 to 32, the carry-out is source bit n−1 and the upper n bits of the result are zero. For distances of 32 or more the result is 0. For distances above 32 the carry-out is 0.
- R5: For arithmetic right with a distance n from 1 to 31, the result is the source shifted right by n with copies of bit 31 filled in, and the carry-out is source bit n−1. For distances of 32 or more, every result bit equals source bit 31, and so does the carry-out.
- R6: For rotate right with a nonzero distance, the word rotates right by the distance modulo 32. A multiple of 32 leaves the word unchanged. The carry-out is bit 31 of the rotated result.
- R7: For rotate-right-extended, the distance is ignored. The result is the incoming carry in bit 31 with source bits 31:1 in bits 30:0, and the carry-out is source bit 0.
- R8: Selector codes 5, 6 and 7 return the source unchanged, and the carry-out equals the incoming carry.
- R9: With the output register enabled, the result and the carry-out appear one clock after the inputs are presented. While reset is asserted (active low), both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| srcWord | input | 32 | Word to be shifted |
| shiftSel | input | 3 | Operation selector (see R1) |
| shiftAmt | input | 8 | Shift distance, 0 to 255 |
| carryIn | input | 1 | Current carry flag |
| resWord | output | 32 | Shifted word |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The following properties are checked on every cycle, next to the datapath:
- the pass-through at distance zero;
- the zero result of the logical shifts at large distances;
- the sign fill of the arithmetic shift;
- the link between the rotate carry and bit 31 of the result;
- how rotate-right-extended forms its result;
- that the decoded operation strobes are mutually exclusive.

Some behaviours only the bench scenarios can show. These are the exact carry bit picked for each distance, the rotation modulo 32, and the one-cycle latency with the reset value. The bench compares every result against an independent model, over random distances and the corner distances 0, 1, 31, 32 and 33.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [2:0] {
    SEL_LSL = 3'd0,
    SEL_LSR = 3'd1,
    SEL_ASR = 3'd2,
    SEL_ROR = 3'd3,
    SEL_RRX = 3'd4
  } shiftSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic opLsl;
    logic opLsr;
    logic opAsr;
    logic opRor;
    logic opRrx;
    logic isZero;   // distance == 0
    logic isFull;   // distance == word width
    logic isOver;   // distance > word width
  } shiftCtrl_t;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       shiftSel,
  input  logic [AMT_W-1:0] shiftAmt,
  output shiftCtrl_t       ctrl,
  output logic [LOG_W-1:0] lowAmt
);

  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(W);

  always_comb begin
    ctrl        = '0;
    ctrl.opLsl  = (shiftSel == SEL_LSL);
    ctrl.opLsr  = (shiftSel == SEL_LSR);
    ctrl.opAsr  = (shiftSel == SEL_ASR);
    ctrl.opRor  = (shiftSel == SEL_ROR);
    ctrl.opRrx  = (shiftSel == SEL_RRX);
    ctrl.isZero = (shiftAmt == '0);
    ctrl.isFull = (shiftAmt == WIDTH_AMT);
    ctrl.isOver = (shiftAmt > WIDTH_AMT);
  end

  // Low bits give the in-range distance and the rotate count modulo W
  assign lowAmt = shiftAmt[LOG_W-1:0];

  // R1 / R8: at most one operation strobe; codes 5-7 raise none
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.opLsl, ctrl.opLsr, ctrl.opAsr, ctrl.opRor, ctrl.opRrx}));

  a_r3_range_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl.isZero, ctrl.isFull, ctrl.isOver}) <= 1);

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int W     = 32,
  localparam int LOG_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shiftCtrl_t       ctrl,
  input  logic [LOG_W-1:0] lowAmt,
  input  logic [W-1:0]     srcWord,
  input  logic             carryIn,
  output logic [W-1:0]     shWord,
  output logic             shCarry
);

  logic [LOG_W-1:0] leftIdx;    // W - n, mod W
  logic [LOG_W-1:0] rightIdx;   // n - 1, mod W
  logic [2*W-1:0]   dblWord;
  logic [W-1:0]     rotWord;
  logic signed [W-1:0] asrWord;
  logic             bigAmt;

  assign leftIdx  = LOG_W'(0) - lowAmt;
  assign rightIdx = lowAmt - LOG_W'(1);
  assign dblWord  = {srcWord, srcWord} >> lowAmt;
  assign rotWord  = dblWord[W-1:0];
  assign asrWord  = $signed(srcWord) >>> lowAmt;
  assign bigAmt   = ctrl.isFull | ctrl.isOver;

  always_comb begin
    shWord  = srcWord;
    shCarry = carryIn;
    if (ctrl.opLsl && !ctrl.isZero) begin
      if (bigAmt) begin
        shWord  = '0;
        shCarry = ctrl.isFull ? srcWord[leftIdx] : 1'b0;
      end else begin
        shWord  = srcWord << lowAmt;
        shCarry = srcWord[leftIdx];
      end
    end else if (ctrl.opLsr && !ctrl.isZero) begin
      if (bigAmt) begin
        shWord  = '0;
        shCarry = ctrl.isFull ? srcWord[rightIdx] : 1'b0;
      end else begin
        shWord  = srcWord >> lowAmt;
        shCarry = srcWord[rightIdx];
      end
    end else if (ctrl.opAsr && !ctrl.isZero) begin
      if (bigAmt) begin
        shWord  = {W{srcWord[W-1]}};
        shCarry = srcWord[W-1];
      end else begin
        shWord  = asrWord;
        shCarry = srcWord[rightIdx];
      end
    end else if (ctrl.opRor && !ctrl.isZero) begin
      shWord  = rotWord;
      shCarry = rotWord[W-1];
    end else if (ctrl.opRrx) begin
      shWord  = {carryIn, srcWord[W-1:1]};
      shCarry = srcWord[0];
    end
  end

  a_r1_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.isZero && !ctrl.opRrx) |-> (shWord == srcWord && shCarry == carryIn));

  a_r3_lsl_big_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.opLsl && bigAmt) |-> (shWord == '0));

  a_r4_lsr_over: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.opLsr && ctrl.isOver) |-> (shWord == '0 && !shCarry));

  a_r5_asr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.opAsr && bigAmt) |->
      ($countones(shWord) == (srcWord[W-1] ? W : 0) && shCarry == srcWord[W-1]));

  a_r6_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.opRor && !ctrl.isZero) |->
      (shCarry == shWord[W-1] && $countones(shWord) == $countones(srcWord)));

  a_r7_rrx_form: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.opRrx |-> (shCarry == srcWord[0] && shWord[W-1] == carryIn
                    && shWord[W-2:0] == srcWord[W-1:1]));

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsu_pkg::*;
#(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int LOG_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     srcWord,
  input  logic [2:0]       shiftSel,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             carryIn,
  output logic [W-1:0]     resWord,
  output logic             carryOut
);

  shiftCtrl_t       ctrl;
  logic [LOG_W-1:0] lowAmt;
  logic [W-1:0]     shWord;
  logic             shCarry;

  bsu_ctrl #(.W(W), .AMT_W(AMT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .shiftSel (shiftSel),
    .shiftAmt (shiftAmt),
    .ctrl     (ctrl),
    .lowAmt   (lowAmt)
  );

  bsu_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .lowAmt  (lowAmt),
    .srcWord (srcWord),
    .carryIn (carryIn),
    .shWord  (shWord),
    .shCarry (shCarry)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          resWord  <= '0;
          carryOut <= 1'b0;
        end else begin
          resWord  <= shWord;
          carryOut <= shCarry;
        end
      end
    end else begin : g_comb
      assign resWord  = shWord;
      assign carryOut = shCarry;
    end
  endgenerate

endmodule

// File: tb/sim_barrel_shift_unit.sv
`timescale 1ns/1ps
module sim_barrel_shift_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] srcWord = '0;
  logic [2:0]  shiftSel = '0;
  logic [7:0]  shiftAmt = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resWord;
  logic        carryOut;

  always #2 clk = ~clk;   // 250 MHz

  barrel_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .srcWord(srcWord), .shiftSel(shiftSel),
    .shiftAmt(shiftAmt), .carryIn(carryIn), .resWord(resWord), .carryOut(carryOut)
  );

  typedef struct {
    logic [31:0] expWord;
    logic        expCarry;
    string       tag;
  } item_t;

  item_t q[$];
  int nCmp = 0;
  int nBad = 0;
  bit driving = 1'b1;

  // Independent model built on wide shifts and bit-by-bit rotation
  function automatic void refModel(input logic [31:0] s, input logic [2:0] sel,
      input logic [7:0] a, input logic c, output logic [31:0] w, output logic co);
    logic [64:0] tl;
    logic [32:0] tr;
    logic signed [32:0] ts;
    logic [31:0] rw;
    w = s; co = c;
    case (sel)
      3'd0: if (a != 0) begin
        tl = {33'b0, s};
        tl = (a <= 64) ? (tl << a) : 65'b0;
        w = tl[31:0]; co = tl[32];
      end
      3'd1: if (a != 0) begin
        tr = {s, 1'b0};
        tr = (a <= 33) ? (tr >> a) : 33'b0;
        w = tr[32:1]; co = tr[0];
      end
      3'd2: if (a != 0) begin
        ts = $signed({s, 1'b0});
        ts = ts >>> ((a > 40) ? 40 : a);
        w = ts[32:1]; co = ts[0];
      end
      3'd3: if (a != 0) begin
        rw = s;
        for (int k = 0; k < (a % 32); k++) rw = {rw[0], rw[31:1]};
        w = rw; co = rw[31];
      end
      3'd4: begin w = {c, s[31:1]}; co = s[0]; end
      default: ;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] sel, input logic [7:0] a);
    if (sel > 3'd4) return "R8";
    if (sel == 3'd4) return "R7";
    if (a == 0) return "R1";
    case (sel)
      3'd0: return (a >= 32) ? "R3" : "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [31:0] s, input logic [2:0] sel,
                       input logic [7:0] a, input logic c);
    item_t it;
    @(negedge clk);
    srcWord = s; shiftSel = sel; shiftAmt = a; carryIn = c;
    refModel(s, sel, a, c, it.expWord, it.expCarry);
    it.tag = tagOf(sel, a);
    q.push_back(it);
  endtask

  // Monitor: one registered result per posedge (R9 latency of one clock)
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        it = q.pop_front();
        nCmp++;
        if (resWord !== it.expWord || carryOut !== it.expCarry) begin
          nBad++;
          $display("FAIL %s: got %h/%b expected %h/%b", it.tag,
                   resWord, carryOut, it.expWord, it.expCarry);
        end
      end
    end
  end

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] corners [5] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33};
    // R9: reset state
    repeat (3) @(negedge clk);
    srcWord = 32'hFFFF_FFFF; carryIn = 1'b1; shiftSel = 3'd4;
    @(negedge clk);
    nCmp++;
    if (resWord !== 32'h0 || carryOut !== 1'b0) begin
      nBad++;
      $display("FAIL R9: got %h/%b expected 00000000/0", resWord, carryOut);
    end
    rst_n = 1'b1;

    // Directed corners for every selector
    for (int sel = 0; sel < 8; sel++)
      for (int ci = 0; ci < 5; ci++)
        for (int cb = 0; cb < 2; cb++) begin
          drive(32'h8000_0001, 3'(sel), corners[ci], cb[0]);
          drive(32'h7FFF_FFFE, 3'(sel), corners[ci], cb[0]);
          drive(32'hA5C3_96E1, 3'(sel), corners[ci], cb[0]);
        end

    // Extra boundary distances: multiples of 32 and the top value
    for (int sel = 0; sel < 5; sel++) begin
      drive(32'h1234_5678, 3'(sel), 8'd64, 1'b1);
      drive(32'hF234_5679, 3'(sel), 8'd96, 1'b0);
      drive(32'h8765_4321, 3'(sel), 8'd255, 1'b1);
      drive(32'h4000_0000, 3'(sel), 8'd30, 1'b0);
    end

    // Random sweep over all distances 0-255
    for (int i = 0; i < 2000; i++)
      drive($urandom, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
            1'($urandom_range(0, 1)));

    @(negedge clk);
    drive(32'h0, 3'd0, 8'd0, 1'b0);
    repeat (3) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule